// File: doc/BRIEF.md
# Two-Channel Down-Counting Interval Timer

The block is a register-mapped timer with two independent channels. Each channel has a control word, a reload value and a readable 24-bit counter that steps down once per divided clock tick. The divider is an 8-bit value taken from the control word, so a tick comes every (divider + 1) input clocks. A channel runs either once, stopping at zero, or periodically, reloading from its reload value each time it passes zero. Each channel has an expiry flag in one shared status word, and a single interrupt output combines the flags with their per-channel enables.

Software stops a channel, writes the reload value (which also loads the counter while the channel is stopped), and then writes the control word with the run bit set. Flags are cleared by writing ones to the status word. All register accesses go through one synchronous write strobe with a word address; reads are combinational on the address.

Word addresses (default two channels): 0 control of channel 0, 1 reload of channel 0, 2 counter of channel 0, 3 control of channel 1, 4 reload of channel 1, 5 counter of channel 1, 6 status. Channel c takes addresses 3c, 3c+1 and 3c+2, and status takes 3 × channel count.

Top module: `tmr_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A running channel ticks every (P + 1) clocks, where P is control bits [7:0]. The first tick comes on the (P + 1)-th rising edge after the edge that writes the run bit, because the divider restarts whenever a channel starts.
- R3: The counter register is 24 bits wide and zero-extended on read. Each tick lowers it by one while it is above zero, and writes to the counter address are ignored.
- R4: When control bits [28:27] are anything other than 01, the channel runs once. The tick that finds the counter at zero is the expiry: the counter stays at zero and the run bit (control bit 30) reads 0 afterwards.
- R5: When control bits [28:27] are 01, the tick that finds the counter at zero loads the reload value and counting continues. A reload value of all ones gives a free-running count with a period of 2^24 ticks.
- R6: A reload write while the channel is stopped loads the counter at once. While the channel runs, the write changes only the reload value, and that value is used at the next reload.
- R7: Every expiry sets status bit c for channel c, whatever the interrupt enable (control bit 29) holds.
- R8: Writing the status word clears each flag whose data bit is 1 and leaves flags whose data bit is 0. An expiry in the same cycle as a clear wins, and 0x1F clears all flags.
- R9: `irq` is high exactly when some channel has both its flag and its interrupt enable set.
- R10: A control write with bit 30 at 0 (for example all zeros) stops the channel, and its counter then holds its value.
- R11: Control reads return the run bit at 30, the interrupt enable at 29, the mode at [28:27] and the divider at [7:0]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus changes a channel's counter only through a reload write while the channel is stopped, and that a flag falls only after a status write with a 1 in that bit. They flag any counter movement on an idle stopped channel, any step larger than one on a running channel, and any flag that rises on a channel that was not running. The stimulus keeps to one write per cycle and stops both channels before each random trial. It clears the status before a new reload value and run bit are written, so the expected count, flags and interrupt follow directly from the divider, the reload value and the number of elapsed edges. Divider values stay small and reload values short so that the expiries fall inside each trial's sampling window.

// File: rtl/tmr_pkg.sv
// tmr_pkg: shared constants and the control-word type for the interval timer.
// Assumes a 32-bit register data path; control field positions are fixed.
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int PRE_W    = 8;
    localparam int RUN_BIT  = 30;
    localparam int IEN_BIT  = 29;
    localparam int MODE_MSB = 28;
    localparam int MODE_LSB = 27;

    localparam logic [1:0] MODE_RELOAD = 2'b01;

    typedef struct packed {
        logic             run;
        logic             ien;
        logic [1:0]       mode;
        logic [PRE_W-1:0] div;
    } ctrl_t;

    // Extract the live control fields from a bus word.
    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run  = w[RUN_BIT];
        c.ien  = w[IEN_BIT];
        c.mode = w[MODE_MSB:MODE_LSB];
        c.div  = w[PRE_W-1:0];
        return c;
    endfunction

    // Place the control fields back into a bus word, other bits zero.
    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[RUN_BIT]           = c.run;
        w[IEN_BIT]           = c.ien;
        w[MODE_MSB:MODE_LSB] = c.mode;
        w[PRE_W-1:0]         = c.div;
        return w;
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
// tmr_prescale: divides the clock by (div + 1) into a one-cycle tick.
// Assumes div may change at any time; the phase is cleared while run is low.
module tmr_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;
    logic             wrap;

    assign wrap = (phase_q >= div);
    assign tick = run && wrap;

    // Phase counter: held at zero when stopped, wraps at the divider value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (wrap) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// tmr_channel: one timer channel with control, reload value and down counter.
// Assumes the control and reload strobes are never asserted in the same cycle.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  ctrl_t            ctrl_d,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_d,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    logic [CNT_W-1:0] rld_q;
    logic             tick;
    logic             at_zero;
    logic             periodic;

    tmr_prescale #(.PRE_W(PRE_W)) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl_q.run),
        .div  (ctrl_q.div),
        .tick (tick)
    );

    assign at_zero  = (cnt_q == '0);
    assign periodic = (ctrl_q.mode == MODE_RELOAD);
    assign expire   = tick && at_zero;

    // Control word: bus writes win; a single-run expiry drops the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_d;
        end else if (expire && !periodic) begin
            ctrl_q.run <= 1'b0;
        end
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (rld_we) begin
            rld_q <= rld_d;
        end
    end

    // Down counter: direct load while stopped, step or reload on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rld_we && !ctrl_q.run) begin
            cnt_q <= rld_d;
        end else if (tick) begin
            if (!at_zero) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (periodic) begin
                cnt_q <= rld_q;
            end
        end
    end
endmodule

// File: rtl/tmr_top.sv
// tmr_top: multi-channel interval timer with a shared write-one-to-clear
// status word and a combined interrupt. Assumes CNT_W <= 32 and at most
// 32 channels; reads are combinational on addr.
module tmr_top
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = $clog2(3 * NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(3 * NUM_CH);

    ctrl_t                        ctrl_v [NUM_CH];
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_v;
    logic [NUM_CH-1:0]            expire_v;
    logic [NUM_CH-1:0]            en_v;
    logic [NUM_CH-1:0]            ie_v;
    logic [NUM_CH-1:0]            stat_q;
    logic [NUM_CH-1:0]            clr_mask;
    logic                         unused_wdata;

    assign unused_wdata = ^wdata;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ctrl_we;
        logic rld_we;

        assign ctrl_we = wr_en && (addr == ADDR_W'(3 * c));
        assign rld_we  = wr_en && (addr == ADDR_W'(3 * c + 1));

        tmr_channel #(.CNT_W(CNT_W)) i_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_we(ctrl_we),
            .ctrl_d (ctrl_from_word(wdata)),
            .rld_we (rld_we),
            .rld_d  (wdata[CNT_W-1:0]),
            .ctrl_q (ctrl_v[c]),
            .cnt_q  (cnt_v[c]),
            .expire (expire_v[c])
        );

        assign en_v[c] = ctrl_v[c].run;
        assign ie_v[c] = ctrl_v[c].ien;
    end

    assign clr_mask = (wr_en && addr == STAT_ADDR) ? wdata[NUM_CH-1:0] : '0;

    // Status flags: write-one clears, a fresh expiry sets and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | expire_v;
        end
    end

    assign irq = |(stat_q & ie_v);

    // Read mux over the channel registers and the status word.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(3 * c))     rdata = ctrl_to_word(ctrl_v[c]);
            if (addr == ADDR_W'(3 * c + 2)) rdata = DATA_W'(cnt_v[c]);
        end
        if (addr == STAT_ADDR) rdata = DATA_W'(stat_q);
    end
endmodule

// File: rtl/tmr_chk.sv
// tmr_chk: protocol and state checks for tmr_top, attached by bind.
// Assumes the checked signals come from the top module's own nets.
module tmr_chk #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [31:0]                  wdata,
    input logic                         irq,
    input logic [NUM_CH-1:0]            stat_q,
    input logic [NUM_CH-1:0]            en_v,
    input logic [NUM_CH-1:0]            ie_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(3 * NUM_CH);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R10: a stopped channel with no bus write keeps its count
        a_r10_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_v[i] && !wr_en) |=> $stable(cnt_v[i]));

        // R3: a running channel moves by at most one step below a nonzero count
        a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            (en_v[i] && !wr_en && cnt_v[i] != '0) |=>
            (cnt_v[i] == $past(cnt_v[i]) || cnt_v[i] == $past(cnt_v[i]) - CNT_W'(1)));

        // R7: a flag rises only on a channel that was running
        a_r7_flag_from_run: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[i]) |-> $past(en_v[i]));

        // R8: a flag falls only after a status write with a one in its bit
        a_r8_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_q[i]) |-> $past(wr_en && addr == STAT_ADDR && wdata[i]));
    end

    // R9: no interrupt without a pending flag
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq);

    // R9: no interrupt while every enable is off
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_v == '0) |-> !irq);
endmodule

bind tmr_top tmr_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .irq   (irq),
    .stat_q(stat_q),
    .en_v  (en_v),
    .ie_v  (ie_v),
    .cnt_v (cnt_v)
);

// File: tb/test_tmr_top.sv
// test_tmr_top: directed corner cases plus seeded random trials for tmr_top.
module test_tmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    tmr_top i_tmr_top (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    always #5 clk = ~clk;

    localparam logic [2:0] STAT = 3'd6;

    function automatic logic [2:0] a_ctl(input int ch); return 3'(3 * ch); endfunction
    function automatic logic [2:0] a_rld(input int ch); return 3'(3 * ch + 1); endfunction
    function automatic logic [2:0] a_cnt(input int ch); return 3'(3 * ch + 2); endfunction

    function automatic logic [31:0] mk_ctl(input bit en, input bit ie,
                                           input logic [1:0] mode, input logic [7:0] p);
        return (32'(en) << 30) | (32'(ie) << 29) | (32'(mode) << 27) | 32'(p);
    endfunction

    // Expected count after t ticks from a start value n.
    function automatic logic [31:0] exp_cnt(input bit per, input int n, input int t);
        if (per) return 32'(n - (t % (n + 1)));
        return (t <= n) ? 32'(n - t) : 32'd0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_edges(input int m);
        if (m > 0) begin
            repeat (m) @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and the interrupt
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 32'd0);
        end
        check("R1 reset irq", 32'(irq), 32'd0);

        // R11: control readback keeps only the defined fields
        wr(a_ctl(0), 32'hFFFF_FFFF);
        rd(a_ctl(0), v);
        check("R11 control layout", v, 32'h7800_00FF);
        wr(a_ctl(0), 32'd0);
        wr(STAT, 32'h1F);

        // R4 R7: single run, interrupt disabled, divider 0, start value 2
        wr(a_rld(0), 32'd2);
        wr(a_ctl(0), mk_ctl(1, 0, 2'b00, 8'd0));
        wait_edges(3);
        rd(a_cnt(0), v);  check("R4 count at zero", v, 32'd0);
        rd(STAT, v);      check("R7 flag without enable", v, 32'd1);
        check("R9 irq masked", 32'(irq), 32'd0);
        rd(a_ctl(0), v);  check("R4 run bit cleared", v, 32'd0);
        wait_edges(5);
        rd(a_cnt(0), v);  check("R4 stays at zero", v, 32'd0);

        // R3: counter address ignores writes
        wr(a_cnt(0), 32'h0000_1234);
        rd(a_cnt(0), v);  check("R3 count write ignored", v, 32'd0);

        // R9: enabling the interrupt with a pending flag raises irq
        wr(a_ctl(0), mk_ctl(0, 1, 2'b00, 8'd0));
        check("R9 irq asserted", 32'(irq), 32'd1);

        // R8: zero write keeps, ones clear
        wr(STAT, 32'd0);
        rd(STAT, v);      check("R8 zero write keeps flag", v, 32'd1);
        wr(STAT, 32'h1F);
        rd(STAT, v);      check("R8 clear all", v, 32'd0);
        check("R9 irq after clear", 32'(irq), 32'd0);
        wr(a_ctl(0), 32'd0);

        // R6 R5: periodic channel 1, reload changed while running
        wr(a_rld(1), 32'd5);
        wr(a_ctl(1), mk_ctl(1, 0, 2'b01, 8'd0));
        wait_edges(2);
        rd(a_cnt(1), v);  check("R5 periodic count", v, 32'd3);
        wr(a_rld(1), 32'd9);
        rd(a_cnt(1), v);  check("R6 running reload not loaded", v, 32'd2);
        wait_edges(2);
        rd(a_cnt(1), v);  check("R5 reaches zero", v, 32'd0);
        wait_edges(1);
        rd(a_cnt(1), v);  check("R6 new reload used", v, 32'd9);
        rd(STAT, v);      check("R7 channel 1 flag bit", v, 32'd2);

        // R10: stopping holds the count (the stop edge still ticks)
        wr(a_ctl(1), 32'd0);
        rd(a_cnt(1), v);  check("R10 count at stop", v, 32'd8);
        wait_edges(10);
        rd(a_cnt(1), v);  check("R10 count held", v, 32'd8);
        rd(a_ctl(1), v);  check("R10 control cleared", v, 32'd0);
        wr(STAT, 32'h1F);

        // R5: free-running all-ones reload with divider 1
        wr(a_rld(0), 32'hFFFF_FFFF);
        rd(a_cnt(0), v);  check("R3 24-bit load", v, 32'h00FF_FFFF);
        wr(a_ctl(0), mk_ctl(1, 0, 2'b01, 8'd1));
        wait_edges(7);
        rd(a_cnt(0), v);  check("R5 free run", v, 32'h00FF_FFFC);
        wr(a_ctl(0), 32'd0);

        // R2: divider restarts when a channel starts again
        wr(a_rld(0), 32'd10);
        wr(a_ctl(0), mk_ctl(1, 0, 2'b00, 8'd3));
        wait_edges(6);
        rd(a_cnt(0), v);  check("R2 first divided tick", v, 32'd9);
        wr(a_ctl(0), 32'd0);
        wr(a_ctl(0), mk_ctl(1, 0, 2'b00, 8'd3));
        wait_edges(3);
        rd(a_cnt(0), v);  check("R2 no early tick", v, 32'd9);
        wait_edges(1);
        rd(a_cnt(0), v);  check("R2 full period after start", v, 32'd8);
        wr(a_ctl(0), 32'd0);

        // Random trials over channel, mode, divider, start value and delay
        for (int it = 0; it < 40; it++) begin
            int ch, n, p, m, t;
            bit ie, per, expd;
            logic [1:0] mode;
            ch   = int'($urandom_range(1, 0));
            n    = int'($urandom_range(20, 0));
            p    = int'($urandom_range(3, 0));
            m    = int'($urandom_range(100, 0));
            mode = 2'($urandom_range(3, 0));
            ie   = 1'($urandom_range(1, 0));
            per  = (mode == 2'b01);
            wr(a_ctl(0), 32'd0);
            wr(a_ctl(1), 32'd0);
            wr(STAT, 32'h1F);
            wr(a_rld(ch), 32'(n));
            wr(a_ctl(ch), mk_ctl(1, ie, mode, 8'(p)));
            wait_edges(m);
            t    = m / (p + 1);
            expd = (t >= n + 1);
            rd(a_cnt(ch), v);
            check(per ? "R5 random periodic count" : "R4 random single count",
                  v, exp_cnt(per, n, t));
            rd(STAT, v);
            check("R7 random flag", v, 32'(expd) << ch);
            check("R9 random irq", 32'(irq), 32'(expd && ie));
            rd(a_ctl(ch), v);
            check("R4 random run bit", v, mk_ctl(!(expd && !per), ie, mode, 8'(p)));
        end

        finish_run();
    end
endmodule